// File: doc/BRIEF.md
# Watchdog Interval Timer with Wakeup Settling

This block is an 8-bit up-counter driven by a selectable prescaled tick. When running in interval mode, it gives a periodic interrupt every time the counter rolls over from 0xFF to 0x00. The counter keeps running after each rollover. Software sees two registers: the count, and a control byte. The control byte holds an enable, a mode select, a 3-bit rate select and a sticky overflow flag.

The same counter also times the oscillator settling delay when the chip leaves standby. A standby request is honoured only while the enable bit is clear. When it is honoured:

- the count and the prescaler are reset;
- the chip-wide clock enable drops;
- everything stays frozen until a non-maskable wake pulse arrives.

After the wake pulse, the counter runs at the rate that was selected before standby. Its first rollover raises the clock enable again and ends standby. The interface is plain control pins with a one-cycle write strobe, so no valid/ready flow applies and there is no back-pressure.

Top module: `wdt_interval_settle`

## Requirements
- R1: While running, the counter adds one on each prescaled tick. After 0xFF it continues from 0x00.
- R2: The rate select field is control bits [2:0]. It picks a tick every 2, 64, 128, 256, 512, 1024, 4096 or 8192 input clocks for the codes 0 to 7.
- R3: In interval mode (control bit 5 = 0) with the enable on (control bit 6 = 1), each rollover gives a one-cycle `irq` pulse. Successive pulses are 256 ticks apart.
- R4: Each interval rollover sets the sticky flag in control bit 7. Writing the control register with bit 7 = 0 clears the flag. Writing it with bit 7 = 1 leaves the flag unchanged.
- R5: With the enable clear and no standby in progress, the counter holds its value.
- R6: A `standby_req` pulse that arrives while the enable is set is refused. `clk_en` stays 1 and counting continues.
- R7: An accepted standby request does the following:
  - it sets the count to 0x00;
  - it drives `clk_en` to 0;
  - it freezes the counter and the prescaler until `nmi` is pulsed.
- R8: After `nmi`, the counter counts at the rate selected before standby. `clk_en` returns to 1 on the first rollover, which comes 256 ticks after the wake. No `irq` and no flag are produced during that interval.
- R9: With the mode bit set to 1, the counter still counts, but rollovers raise no `irq`.
- R10: While `clk_en` is 0, register writes have no effect.
- R11: After reset, the count is 0x00 and the control byte is 0x00. `clk_en` is 1 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | One-cycle register write strobe |
| reg_addr | input | 1 | Register select: 0 for count, 1 for control |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the register selected by `reg_addr` |
| standby_req | input | 1 | Low-power entry request pulse |
| nmi | input | 1 | Wake pulse from standby |
| irq | output | 1 | Interval interrupt pulse |
| clk_en | output | 1 | Clock enable for the rest of the chip |

## Verification
The hardest case to reach from the ports is the wake-up settling path. To get there, the enable must first be cleared and a rate written. Then a standby request must be accepted, and a long frozen stretch must pass before the wake pulse. The stimulus selects the /64 rate and disables the timer. It enters standby, attempts a count write, and idles for a thousand cycles with the count unchanged. It then pulses `nmi` and measures the cycles until `clk_en` returns, while a monitor confirms that no interrupt fires during that interval.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    PH_RUN    = 2'd0,
    PH_SLEEP  = 2'd1,
    PH_SETTLE = 2'd2
  } phase_t;

  // log2 of the divide ratio picked by each rate-select code
  function automatic int unsigned div_log2(input int unsigned code);
    case (code)
      0: div_log2 = 1;
      1: div_log2 = 6;
      2: div_log2 = 7;
      3: div_log2 = 8;
      4: div_log2 = 9;
      5: div_log2 = 10;
      6: div_log2 = 12;
      default: div_log2 = 13;
    endcase
  endfunction
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int PRE_W = 13,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             hold,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  import wdt_pkg::*;
  localparam int NSEL = 1 << SEL_W;

  logic [PRE_W-1:0] pre;
  logic [NSEL-1:0]  taps;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pre <= '0;
    else if (clear) pre <= '0;
    else if (!hold) pre <= pre + 1'b1;
  end

  // one tap per selectable ratio: low bits all ones marks the last cycle of a period
  for (genvar i = 0; i < NSEL; i++) begin : g_tap
    localparam int L = div_log2(i);
    assign taps[i] = &pre[L-1:0];
  end

  assign tick = !hold && !clear && taps[sel];

  assert_prescale_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !clear) |=> (hold || $stable(pre)) && (!hold || $stable(pre)));
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         inc,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  assign wrap = inc && (&cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clear) cnt <= '0;
    else if (wr_en) cnt <= wr_data;
    else if (inc)   cnt <= cnt + 1'b1;
  end

  assert_wrap_to_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !wr_en && !clear) |=> (cnt == '0));
  assert_hold_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !wr_en && !clear) |=> $stable(cnt));
endmodule

// File: rtl/wdt_interval_settle.sv
module wdt_interval_settle #(
  parameter int CNT_W = 8,
  parameter int PRE_W = 13,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_addr,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  input  logic             standby_req,
  input  logic             nmi,
  output logic             irq,
  output logic             clk_en
);
  import wdt_pkg::*;
  localparam int FLAG_B = CNT_W - 1;
  localparam int EN_B   = CNT_W - 2;
  localparam int MODE_B = CNT_W - 3;

  phase_t           phase;
  logic             run_en, mode_q, flag_q;
  logic [SEL_W-1:0] sel_q;
  logic             tick, wrap, inc, accept, woke;
  logic             wr_cnt, wr_ctl, ivl_event;
  logic [CNT_W-1:0] cnt;

  assign accept    = (phase == PH_RUN) && standby_req && !run_en;
  assign inc       = tick && (((phase == PH_RUN) && run_en) || (phase == PH_SETTLE));
  assign woke      = (phase == PH_SETTLE) && wrap;
  assign wr_cnt    = reg_wr && !reg_addr && (phase == PH_RUN);
  assign wr_ctl    = reg_wr && reg_addr && (phase == PH_RUN);
  assign ivl_event = wrap && (phase == PH_RUN) && !mode_q;

  wdt_prescaler #(.PRE_W(PRE_W), .SEL_W(SEL_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .clear(accept),
    .hold(phase == PH_SLEEP), .sel(sel_q), .tick(tick)
  );

  wdt_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clear(accept), .wr_en(wr_cnt),
    .wr_data(reg_wdata), .inc(inc), .cnt(cnt), .wrap(wrap)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_RUN;
      clk_en <= 1'b1;
    end else begin
      case (phase)
        PH_RUN:    if (accept) begin phase <= PH_SLEEP; clk_en <= 1'b0; end
        PH_SLEEP:  if (nmi) phase <= PH_SETTLE;
        PH_SETTLE: if (woke) begin phase <= PH_RUN; clk_en <= 1'b1; end
        default:   phase <= PH_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_en <= 1'b0;
      mode_q <= 1'b0;
      sel_q  <= '0;
      flag_q <= 1'b0;
      irq    <= 1'b0;
    end else begin
      irq <= ivl_event;
      if (wr_ctl) begin
        run_en <= reg_wdata[EN_B];
        mode_q <= reg_wdata[MODE_B];
        sel_q  <= reg_wdata[SEL_W-1:0];
      end
      if (ivl_event)                          flag_q <= 1'b1;
      else if (wr_ctl && !reg_wdata[FLAG_B]) flag_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr) begin
      reg_rdata[FLAG_B]    = flag_q;
      reg_rdata[EN_B]      = run_en;
      reg_rdata[MODE_B]    = mode_q;
      reg_rdata[SEL_W-1:0] = sel_q;
    end else begin
      reg_rdata = cnt;
    end
  end

  assert_irq_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  assert_irq_sets_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag_q);
  assert_refuse_standby_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase == PH_RUN) && run_en && standby_req) |=> (phase == PH_RUN) && clk_en);
  assert_sleep_gates_clock_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SLEEP) |-> !clk_en);
  assert_sleep_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase == PH_SLEEP) && !nmi) |=> $stable(cnt));
  assert_settle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SETTLE) |=> !irq);
  assert_mode_mutes_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q |=> !irq);
  assert_locked_writes_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en && reg_wr && reg_addr) |=> $stable(sel_q) && $stable(run_en));
endmodule

// File: tb/wdt_interval_settle_tb.sv
module wdt_interval_settle_tb;
  logic       clk = 0, rst_n = 0;
  logic       reg_wr = 0, reg_addr = 0, standby_req = 0, nmi = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic       irq, clk_en;
  int checks = 0, fails = 0, cyc = 0, irq_seen = 0;

  wdt_interval_settle u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .standby_req(standby_req),
    .nmi(nmi), .irq(irq), .clk_en(clk_en)
  );

  always #2 clk = ~clk;
  always @(posedge clk) begin
    cyc++;
    if (irq) irq_seen++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic a, output int v);
    reg_addr = a; #1; v = reg_rdata;
  endtask

  task automatic wait_irq(output int at);
    int guard = 0;
    @(negedge clk);
    while (!irq && guard < 40000) begin @(negedge clk); guard++; end
    at = cyc;
  endtask

  task automatic t_reset;
    int v;
    @(negedge clk);
    rd(0, v); chk(v == 0, "R11 count", v, 0);
    rd(1, v); chk(v == 0, "R11 ctrl", v, 0);
    chk(clk_en == 1, "R11 clk_en", clk_en, 1);
    chk(irq == 0, "R11 irq", irq, 0);
  endtask

  task automatic t_rate;
    int v;
    wr(0, 8'd0); wr(1, 8'h40);            // enable, interval, /2
    repeat (200) @(negedge clk);
    rd(0, v); chk(v >= 99 && v <= 102, "R1 count rate /2", v, 100);
  endtask

  task automatic t_interval(input logic [2:0] sel, input int expgap);
    int a, b, v;
    wr(1, {5'b01000, sel});
    wait_irq(a); wait_irq(b);
    chk(b - a == expgap, "R2 R3 irq spacing", b - a, expgap);
    @(negedge clk);
    chk(irq == 0, "R3 irq one cycle", irq, 0);
    rd(1, v); chk(v[7] == 1, "R4 flag set", v[7], 1);
    rd(0, v); chk(v <= 2, "R1 continues after wrap", v, 0);
  endtask

  task automatic t_flag;
    int v;
    wr(1, 8'hC0);                          // bit7=1: no effect
    rd(1, v); chk(v[7] == 1, "R4 write one keeps flag", v[7], 1);
    wr(1, 8'h40);                          // bit7=0: clear
    rd(1, v); chk(v[7] == 0, "R4 write zero clears", v[7], 0);
  endtask

  task automatic t_mode;
    int s0, v;
    wr(1, 8'h60);                          // enable, mode=1, /2
    s0 = irq_seen;
    repeat (1100) @(negedge clk);
    chk(irq_seen == s0, "R9 no irq in mode 1", irq_seen - s0, 0);
    rd(1, v); chk(v[7] == 0, "R9 no flag in mode 1", v[7], 0);
  endtask

  task automatic t_hold;
    int a, b;
    wr(1, 8'h00);
    rd(0, a); repeat (300) @(negedge clk); rd(0, b);
    chk(a == b, "R5 disabled counter holds", b, a);
  endtask

  task automatic t_refuse;
    int a, b;
    wr(1, 8'h40);
    rd(0, a);
    @(negedge clk); standby_req = 1; @(negedge clk); standby_req = 0;
    repeat (20) @(negedge clk);
    chk(clk_en == 1, "R6 standby refused", clk_en, 1);
    rd(0, b); chk(b != a, "R6 counting continues", b, a);
  endtask

  task automatic t_standby;
    int v, t0, n, s0;
    wr(1, 8'h01);                          // disabled, /64
    wr(0, 8'h37);
    @(negedge clk); standby_req = 1; @(negedge clk); standby_req = 0;
    chk(clk_en == 0, "R7 clk_en drops", clk_en, 0);
    rd(0, v); chk(v == 0, "R7 count cleared", v, 0);
    wr(0, 8'h55); wr(1, 8'h47);
    rd(0, v); chk(v == 0, "R10 count write ignored", v, 0);
    rd(1, v); chk(v == 8'h01, "R10 ctrl write ignored", v, 1);
    repeat (1000) @(negedge clk);
    rd(0, v); chk(v == 0, "R7 frozen before wake", v, 0);
    chk(clk_en == 0, "R7 clk_en stays low", clk_en, 0);
    s0 = irq_seen;
    nmi = 1; @(negedge clk); nmi = 0;
    t0 = cyc; n = 0;
    while (!clk_en && n < 20000) begin @(negedge clk); n++; end
    chk((cyc - t0) >= 16384 - 70 && (cyc - t0) <= 16384 + 70,
        "R8 settle time 256 ticks at /64", cyc - t0, 16384);
    chk(irq_seen == s0, "R8 no irq during settle", irq_seen - s0, 0);
    rd(1, v); chk(v[7] == 0, "R8 no flag during settle", v[7], 0);
    rd(0, v); chk(v == 0, "R8 count wrapped at wake", v, 0);
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_rate;
    t_interval(3'd0, 512);
    t_flag;
    t_interval(3'd2, 32768);
    t_mode;
    t_hold;
    t_refuse;
    t_standby;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule